// File: doc/BRIEF.md
# Sign-Magnitude PWM Motor Drive Output

This block turns a signed 8-bit motor command into three drive signals. It gives a parallel code for a bipolar DAC, a pulse-width-modulated pulse and a direction line. The command arrives in two's complement. Internally it is split into a magnitude and a sign. The magnitude sets how many clocks the pulse stays high in each frame, and the frame has a fixed length.

A frame lasts `FRAME_LEN` system clocks, 100 by default. The pulse frequency is therefore the clock divided by 100, and the duty cycle is resolved in single-clock steps. The command on the input is captured only in the last clock of a frame. Each frame therefore plays one command from start to end and is never cut short. A supervisor can assert a force-zero input. It silences the pulse and parks the DAC code at zero-command at once, while the frame timing keeps running underneath.

Top module: `motor_pwm_out`

## Requirements
- R1: While reset is asserted, `dac_o` is 0x80, `pulse_o` is 0 and `sign_o` is 0, whatever the value of `cmd_i`.
- R2: `dac_o` is the latched command in offset binary: the two's-complement command with bit 7 inverted. So 0x80 means zero, 0xFF means +127 and 0x00 means -128. Bit 7 is the most significant bit.
- R3: A frame is exactly 100 clocks. The first frame starts in the first clock after reset is released, and each later frame starts right after the previous one ends.
- R4: For a latched magnitude m from 1 to 99, `pulse_o` is high in the first m clocks of the frame and low for the remaining 100-m clocks.
- R5: A magnitude of 100 or more keeps `pulse_o` high for all 100 clocks of the frame. This includes -128, whose magnitude is 128.
- R6: A zero command keeps `pulse_o` low for the whole frame.
- R7: `sign_o` is 1 for a negative latched command and 0 for a zero or positive one.
- R8: `cmd_i` is sampled only in the last clock of a frame and takes effect from the first clock of the next frame. Changes to `cmd_i` at any other time do not alter `dac_o`, `sign_o` or the pulse width of the current frame.
- R9: In every clock where `force_zero_i` is 1, `dac_o` is 0x80 and `pulse_o` and `sign_o` are 0. This takes effect in the same clock the input rises. Frame timing and command capture continue underneath, so the outputs follow the latched command again from the first clock after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one pulse-width step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 8 | Signed two's-complement motor command |
| force_zero_i | input | 1 | Supervisor force-zero; silences the outputs while high |
| dac_o | output | 8 | Offset-binary code for a bipolar DAC |
| pulse_o | output | 1 | PWM pulse, high for the magnitude in clocks at the frame start |
| sign_o | output | 1 | Direction: 1 for a negative command |

## Verification
Force-zero and the frame-boundary capture can fall in the same clock. The bench provokes this by raising force-zero late in a frame where the pulse is full-width. It holds force-zero across the boundary while a new command is presented, and releases it a few clocks into the next frame. The scoreboard then expects the silenced outputs during the overlap and the new command's code, sign and remaining pulse right after release, which shows that capture went ahead under force. Separately, every frame presents a different junk command in mid-frame before the real one. A capture at the wrong time shows up as a wrong code or pulse width in the frame being played.

// File: rtl/motor_pwm_pkg.sv
package motor_pwm_pkg;

    localparam int CMD_W = 8;
    localparam logic [CMD_W-1:0] ZERO_CODE = {1'b1, {(CMD_W-1){1'b0}}};

    typedef struct packed {
        logic             neg;
        logic [CMD_W-1:0] mag;
    } drive_t;

    function automatic logic [CMD_W-1:0] abs_cmd(input logic [CMD_W-1:0] c);
        return c[CMD_W-1] ? (~c + 1'b1) : c;
    endfunction

    function automatic drive_t split_cmd(input logic [CMD_W-1:0] c,
                                         input int unsigned      frame_len);
        drive_t           d;
        logic [CMD_W-1:0] m;
        m     = abs_cmd(c);
        d.neg = c[CMD_W-1];
        d.mag = (32'(m) >= frame_len) ? CMD_W'(frame_len) : m;
        return d;
    endfunction

    function automatic logic [CMD_W-1:0] to_offset(input logic [CMD_W-1:0] c);
        return c ^ ZERO_CODE;
    endfunction

endpackage

// File: rtl/pwm_frame_timer.sv
module pwm_frame_timer #(
    parameter int FRAME_LEN = 100,
    localparam int CNT_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o,
    output logic             frame_end_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o       = cnt_q;
    assign frame_end_o = (cnt_q == LAST);

    // R3: the frame wraps to its first clock after the last one
    p_frame_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        frame_end_o |=> (cnt_q == '0));

    // R3: inside a frame the position advances by one each clock
    p_frame_step_r3: assert property (@(posedge clk) disable iff (rst)
        !frame_end_o |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/pwm_cmd_latch.sv
module pwm_cmd_latch
    import motor_pwm_pkg::*;
#(
    parameter int FRAME_LEN = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CMD_W-1:0] cmd_i,
    output drive_t           drv_o,
    output logic [CMD_W-1:0] dac_o
);
    drive_t           drv_q;
    logic [CMD_W-1:0] dac_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q <= '0;
            dac_q <= ZERO_CODE;
        end else if (load_i) begin
            drv_q <= split_cmd(cmd_i, FRAME_LEN);
            dac_q <= to_offset(cmd_i);
        end
    end

    assign drv_o = drv_q;
    assign dac_o = dac_q;

    // R8: nothing latched changes except on the frame boundary
    p_hold_mid_frame_r8: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> ($stable(drv_q) && $stable(dac_q)));

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
    import motor_pwm_pkg::*;
#(
    parameter int FRAME_LEN = 100,
    localparam int CNT_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CMD_W-1:0] mag_i,
    output logic             pulse_o
);
    assign pulse_o = (32'(cnt_i) < 32'(mag_i));

    // R4: a pulse may only begin at the first clock of a frame
    p_rise_at_start_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |-> (cnt_i == '0));

endmodule

// File: rtl/motor_pwm_out.sv
module motor_pwm_out
    import motor_pwm_pkg::*;
#(
    parameter int FRAME_LEN = 100,
    localparam int CNT_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             force_zero_i,
    output logic [CMD_W-1:0] dac_o,
    output logic             pulse_o,
    output logic             sign_o
);
    logic [CNT_W-1:0] cnt;
    logic             frame_end;
    drive_t           drv;
    logic [CMD_W-1:0] dac_q;
    logic             pulse_raw;

    pwm_frame_timer #(.FRAME_LEN(FRAME_LEN)) timer_i (
        .clk         (clk),
        .rst         (rst),
        .cnt_o       (cnt),
        .frame_end_o (frame_end)
    );

    pwm_cmd_latch #(.FRAME_LEN(FRAME_LEN)) latch_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (frame_end),
        .cmd_i  (cmd_i),
        .drv_o  (drv),
        .dac_o  (dac_q)
    );

    pwm_compare #(.FRAME_LEN(FRAME_LEN)) cmp_i (
        .clk     (clk),
        .rst     (rst),
        .cnt_i   (cnt),
        .mag_i   (drv.mag),
        .pulse_o (pulse_raw)
    );

    assign dac_o   = force_zero_i ? ZERO_CODE : dac_q;
    assign sign_o  = drv.neg & ~force_zero_i;
    assign pulse_o = pulse_raw & ~force_zero_i;

    // R7: a negative direction always pairs with a code below zero-command
    p_sign_vs_code_r7: assert property (@(posedge clk) disable iff (rst)
        sign_o |-> !dac_o[CMD_W-1]);

    // R9: force-zero silences every output
    p_force_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        force_zero_i |-> ((dac_o == ZERO_CODE) && !pulse_o && !sign_o));

endmodule

// File: tb/motor_pwm_out_tb.sv
module motor_pwm_out_tb_top;

    localparam int FRAME = 100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cmd = 8'h00;
    logic       frc = 1'b0;
    logic [7:0] dac;
    logic       pulse;
    logic       sign;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    int  ph     = 0;

    logic [7:0] sb_q[$];

    always #10 clk = ~clk;

    motor_pwm_out #(.FRAME_LEN(FRAME)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .cmd_i        (cmd),
        .force_zero_i (frc),
        .dac_o        (dac),
        .pulse_o      (pulse),
        .sign_o       (sign)
    );

    // R3 model: frame position, first frame starts after reset release
    always @(posedge clk) begin
        if (rst) ph <= 0;
        else     ph <= (ph == FRAME - 1) ? 0 : ph + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d ph=%0d t=%0t", tag, act, exp, ph, $time);
        end
    endtask

    // Driver: one full frame; junk at 20, real command at 50 (captured at 99)
    task automatic step(input logic [7:0] c, input int fon, input int foff);
        while (ph != 0) begin @(posedge clk); #1; end
        for (int p = 0; p < FRAME; p++) begin
            if (p == fon)  frc = 1'b1;
            if (p == foff) frc = 1'b0;
            if (p == 20)   cmd = ~c;
            if (p == 50) begin
                cmd = c;
                sb_q.push_back(c);
            end
            @(posedge clk); #1;
        end
    endtask

    // Monitor / scoreboard
    initial begin
        logic [7:0] cur;
        bit         active;
        int         mag;
        int         width;
        logic [7:0] edac;
        bit         esg;
        bit         epl;
        string      ptag;
        cur    = 8'h00;
        active = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (ph == 0 && sb_q.size() > 0) begin
                    cur    = sb_q.pop_front();
                    active = 1'b1;
                end
                if (active) begin
                    mag   = cur[7] ? 256 - int'(cur) : int'(cur);
                    width = (mag >= FRAME) ? FRAME : mag;
                    edac  = frc ? 8'h80 : (cur ^ 8'h80);
                    esg   = frc ? 1'b0 : cur[7];
                    epl   = !frc && (ph < width);
                    if (frc)               ptag = "R9 pulse";
                    else if (width == 0)   ptag = "R6 pulse";
                    else if (width == FRAME) ptag = "R5 pulse";
                    else                   ptag = "R4/R3/R8 pulse";
                    check(dac == edac, frc ? "R9 dac" : "R2/R8 dac", int'(dac), int'(edac));
                    check(sign == esg, frc ? "R9 sign" : "R7/R8 sign", int'(sign), int'(esg));
                    check(pulse == epl, ptag, int'(pulse), int'(epl));
                end
            end
        end
    end

    // Main sequence
    initial begin
        cmd = 8'h55;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(dac == 8'h80, "R1 dac", int'(dac), 8'h80);
        check(pulse == 1'b0, "R1 pulse", int'(pulse), 0);
        check(sign == 1'b0, "R1 sign", int'(sign), 0);
        @(posedge clk); #1;
        rst = 1'b0;

        step(8'd0,   -1, -1);
        step(8'd1,   -1, -1);
        step(8'd50,  -1, -1);
        step(8'd99,  -1, -1);
        step(8'd100, -1, -1);
        step(8'd127, -1, -1);
        step(8'hFF,  40, 60);
        step(8'hCE,  -1, -1);
        step(8'h9D,  10, 25);
        step(8'h9C,  -1, -1);
        step(8'h80,  -1, -1);
        step(8'd60,  95, -1);
        step(8'd0,   -1,  3);
        step(8'd0,   -1, -1);
        repeat (2 * FRAME) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule